// File: doc/BRIEF.md
# NAND Flash Command Interface Model

This block models the device side of an 8-bit, small-page NAND flash. A host drives command bytes while the command latch is high and address bytes while the address latch is high. With neither latch high, the same write strobe carries program data. Each read strobe pulls one byte out. The block keeps a page buffer of one main area plus a spare area of one thirty-second of the page size. It answers identification and status queries by itself and sequences page data out of that buffer.

Actual array work is left to a separate engine. The block raises a one-cycle load, program or erase request together with a row number. The engine fills the buffer through a fill port, reads programmed data through a drain port, and reports busy, done and fail.

Top module: `nand_cmd_if`

## Requirements
- R1: After reset the data output is 0x00, no request is raised, and `ready` is the inverse of `arr_busy`.
- R2: Address bytes are accepted only on write strobes with the address latch high and the command latch low, and are stored lowest byte first. Any recognised command byte restarts the address byte count.
- R3: Command 0x00 followed by three address bytes raises `load_req`. Reading then begins at the column given by address byte 0 and advances one byte per read strobe. The read delivers (page + page/32 − column) bytes, or (page − column) bytes while `spare_off` is high, and returns 0x00 after that.
- R4: Command 0x01 shifts the read start to column + 256.
- R5: Command 0x50 shifts the read start to column + page size, which lies in the spare area. With `spare_off` high this leaves no bytes, so reads return 0x00.
- R6: Command 0x90 followed by one address byte makes the next four reads return the manufacturer code, the device code, a filler byte (parameters, defaults 0xEC, 0x75, 0x51) and 0xC0, then 0x00.
- R7: After command 0x70 every read returns the status byte and consumes nothing, until another recognised command arrives. Status layout: bit 7 = `wp_n`, bit 6 = ready, bit 0 = error, bits 5..1 = 0.
- R8: The error bit takes the value of `arr_fail` on an `arr_done` pulse. Command 0xFF clears it.
- R9: Command 0x80 plus three address bytes sets the program write position to the read start offset. Each following data byte is stored there and the position advances, with nothing stored at or beyond page + page/32. Command 0x10 raises `prog_req` with row {byte2, byte1}, but only while `wp_n` is high.
- R10: Command 0x60 plus two address bytes, then 0xD0, raises `erase_req` with row {byte1, byte0}, but only while `wp_n` is high.
- R11: While `ce_n` is high the output is 0x00 and every strobe is ignored, so the read position does not move.
- R12: Command bytes other than 0x00, 0x01, 0x50, 0x90, 0xFF, 0x80, 0x10, 0x60, 0xD0 and 0x70 change nothing, including an active status echo.
- R13: Command 0xFF returns to read 0x00 mode, clears the pending start offset and the address bytes, and makes the output 0x00.
- R14: `load_req` is a single-cycle pulse with `req_row` = {byte2, byte1}. At most one request is raised at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | High = not write protected |
| spare_off | input | 1 | Leave the spare area out of page reads |
| wr_stb | input | 1 | Write strobe for command, address or data |
| din | input | 8 | Byte written by the host |
| rd_stb | input | 1 | Read strobe, consumes one output byte |
| dout | output | 8 | Current output byte |
| ready | output | 1 | High when the array engine is idle |
| load_req | output | 1 | Page load request pulse |
| prog_req | output | 1 | Program request pulse |
| erase_req | output | 1 | Erase request pulse |
| req_row | output | 16 | Row for the current request |
| arr_busy | input | 1 | Array engine busy |
| arr_done | input | 1 | Array operation finished pulse |
| arr_fail | input | 1 | Result of the finished operation |
| fill_we | input | 1 | Engine write into the page buffer |
| fill_col | input | COLW | Buffer column for the engine write |
| fill_data | input | 8 | Byte for the engine write |
| drain_col | input | COLW | Buffer column for the engine read |
| drain_data | output | 8 | Buffer byte at `drain_col` |

## Verification
The bench starts reads at columns near the end of the page and in the spare area. A wrong length or offset shows up as a byte too many, a byte too few, or a pattern shifted by 256 or by the page size. It splits an address sequence with a second command. A counter that is not cleared would then load on the wrong byte. It sends an unknown byte during a status echo: a decoder that accepts it would drop out of the echo. It also programs past the buffer end and checks the buffer for wrap-around. It issues 0x01 before a reset command: a stale offset would survive the reset and move the next read by 256.

// File: rtl/nand_if_pkg.sv
package nand_if_pkg;

  localparam logic [7:0] OP_RD_COL   = 8'h00;
  localparam logic [7:0] OP_RD_HALF  = 8'h01;
  localparam logic [7:0] OP_RD_SPARE = 8'h50;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_RESET    = 8'hFF;
  localparam logic [7:0] OP_WR_SETUP = 8'h80;
  localparam logic [7:0] OP_WR_GO    = 8'h10;
  localparam logic [7:0] OP_ER_SETUP = 8'h60;
  localparam logic [7:0] OP_ER_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS   = 8'h70;

  typedef enum logic [2:0] {
    CM_READ, CM_IDENT, CM_WRITE, CM_WRITE_GO, CM_ERASE, CM_ERASE_GO, CM_STATUS
  } cmd_t;

  typedef enum logic [1:0] {OS_COL, OS_HALF, OS_SPARE} offs_t;

  typedef enum logic [1:0] {OUT_NONE, OUT_PAGE, OUT_IDENT, OUT_STAT} omode_t;

  function automatic logic op_known(logic [7:0] op);
    case (op)
      OP_RD_COL, OP_RD_HALF, OP_RD_SPARE, OP_IDENT, OP_RESET,
      OP_WR_SETUP, OP_WR_GO, OP_ER_SETUP, OP_ER_GO, OP_STATUS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // First buffer index touched by a read or program.
  function automatic int unsigned first_col(offs_t sel, logic [7:0] col, int unsigned page);
    int unsigned base;
    case (sel)
      OS_HALF:  base = 256;
      OS_SPARE: base = page;
      default:  base = 0;
    endcase
    return base + 32'(col);
  endfunction

  // Bytes a page read can deliver from a given start.
  function automatic int unsigned bytes_left(int unsigned start, logic sup, int unsigned page);
    int unsigned lim;
    lim = sup ? page : page + page / 32;
    return (start < lim) ? lim - start : 0;
  endfunction

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_if_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        cle,
  input  logic        ale,
  input  logic        wp_n,
  input  logic        wr_stb,
  input  logic [7:0]  din,
  output logic        ev_cmd,
  output logic        ev_status,
  output logic        ev_reset,
  output logic        ev_load,
  output logic        ev_wstart,
  output logic        ev_data,
  output logic        ev_ident,
  output logic [7:0]  cur_col,
  output offs_t       cur_sel,
  output logic        load_req,
  output logic        prog_req,
  output logic        erase_req,
  output logic [15:0] req_row
);

  cmd_t            cur;
  offs_t           sel;
  logic [2:0]      cnt;
  logic [2:0][7:0] abyte;

  logic wr_ok, cmd_cyc, adr_cyc, dat_cyc, ev_pgo, ev_ego;

  assign wr_ok   = wr_stb & ~ce_n;
  assign cmd_cyc = wr_ok & cle;
  assign adr_cyc = wr_ok & ~cle & ale;
  assign dat_cyc = wr_ok & ~cle & ~ale;

  assign ev_cmd    = cmd_cyc & op_known(din);
  assign ev_status = ev_cmd & (din == OP_STATUS);
  assign ev_reset  = ev_cmd & (din == OP_RESET);
  assign ev_pgo    = ev_cmd & (din == OP_WR_GO) & wp_n;
  assign ev_ego    = ev_cmd & (din == OP_ER_GO) & wp_n;
  assign ev_ident  = adr_cyc & (cur == CM_IDENT) & (cnt == 3'd0);
  assign ev_load   = adr_cyc & (cur == CM_READ)  & (cnt == 3'd2);
  assign ev_wstart = adr_cyc & (cur == CM_WRITE) & (cnt == 3'd2);
  assign ev_data   = dat_cyc & (cur == CM_WRITE);

  assign cur_col = abyte[0];
  assign cur_sel = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= CM_READ;
      sel       <= OS_COL;
      cnt       <= '0;
      abyte     <= '0;
      load_req  <= 1'b0;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      req_row   <= '0;
    end else begin
      load_req  <= ev_load;
      prog_req  <= ev_pgo;
      erase_req <= ev_ego;
      if (ev_load) req_row <= {din, abyte[1]};
      if (ev_pgo)  req_row <= {abyte[2], abyte[1]};
      if (ev_ego)  req_row <= {abyte[1], abyte[0]};
      if (ev_cmd) begin
        cnt <= '0;
        case (din)
          OP_RD_COL:   begin cur <= CM_READ; sel <= OS_COL;   end
          OP_RD_HALF:  begin cur <= CM_READ; sel <= OS_HALF;  end
          OP_RD_SPARE: begin cur <= CM_READ; sel <= OS_SPARE; end
          OP_IDENT:    cur <= CM_IDENT;
          OP_WR_SETUP: cur <= CM_WRITE;
          OP_WR_GO:    cur <= CM_WRITE_GO;
          OP_ER_SETUP: cur <= CM_ERASE;
          OP_ER_GO:    cur <= CM_ERASE_GO;
          OP_STATUS:   cur <= CM_STATUS;
          default: begin
            cur   <= CM_READ;
            sel   <= OS_COL;
            abyte <= '0;
          end
        endcase
      end else if (adr_cyc) begin
        if (cnt < 3'd3) abyte[cnt[1:0]] <= din;
        if (cnt != 3'd7) cnt <= cnt + 3'd1;
        if (ev_load || ev_wstart) sel <= OS_COL;
      end
    end
  end

endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int TOTAL = 528,
  parameter int COLW  = 10
) (
  input  logic            clk,
  input  logic            fill_we,
  input  logic [COLW-1:0] fill_col,
  input  logic [7:0]      fill_data,
  input  logic            host_we,
  input  logic [COLW-1:0] host_col,
  input  logic [7:0]      host_data,
  input  logic [COLW-1:0] rd_col,
  output logic [7:0]      rd_data,
  input  logic [COLW-1:0] drain_col,
  output logic [7:0]      drain_data
);

  logic [7:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (fill_we && fill_col < COLW'(TOTAL))
      mem[fill_col] <= fill_data;
    else if (host_we && host_col < COLW'(TOTAL))
      mem[host_col] <= host_data;
  end

  assign rd_data    = (rd_col    < COLW'(TOTAL)) ? mem[rd_col]    : 8'h00;
  assign drain_data = (drain_col < COLW'(TOTAL)) ? mem[drain_col] : 8'h00;

endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
  import nand_if_pkg::*;
#(
  parameter int         PAGE_BYTES = 512,
  parameter logic [7:0] MANUF_ID   = 8'hEC,
  parameter logic [7:0] DEVICE_ID  = 8'h75,
  parameter logic [7:0] FILLER     = 8'h51,
  parameter int         COLW       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            rd_stb,
  input  logic            spare_off,
  input  logic [7:0]      din,
  input  logic            ev_cmd,
  input  logic            ev_status,
  input  logic            ev_load,
  input  logic            ev_wstart,
  input  logic            ev_data,
  input  logic            ev_ident,
  input  logic [7:0]      cur_col,
  input  offs_t           cur_sel,
  input  logic [7:0]      rd_data,
  input  logic [7:0]      status_byte,
  output logic [7:0]      dout,
  output logic [COLW-1:0] rd_col,
  output logic            buf_we,
  output logic [COLW-1:0] buf_col,
  output logic [7:0]      buf_data,
  output logic            in_status
);

  localparam int TOTAL = PAGE_BYTES + PAGE_BYTES / 32;

  omode_t          mode;
  logic [COLW-1:0] ptr, left, wptr, start_w, len_w;
  logic            take;

  function automatic logic [7:0] ident_byte(logic [1:0] i);
    case (i)
      2'd0:    return MANUF_ID;
      2'd1:    return DEVICE_ID;
      2'd2:    return FILLER;
      default: return 8'hC0;
    endcase
  endfunction

  assign start_w = COLW'(first_col(cur_sel, cur_col, PAGE_BYTES));
  assign len_w   = COLW'(bytes_left(first_col(cur_sel, cur_col, PAGE_BYTES),
                                    spare_off, PAGE_BYTES));
  assign take    = rd_stb & ~ce_n & (left != '0) &
                   ((mode == OUT_PAGE) || (mode == OUT_IDENT));

  assign in_status = (mode == OUT_STAT);
  assign rd_col    = ptr;
  assign buf_we    = ev_data & (wptr < COLW'(TOTAL));
  assign buf_col   = wptr;
  assign buf_data  = din;

  always_comb begin
    dout = 8'h00;
    if (!ce_n) begin
      if (mode == OUT_STAT)
        dout = status_byte;
      else if (left != '0 && mode == OUT_PAGE)
        dout = rd_data;
      else if (left != '0 && mode == OUT_IDENT)
        dout = ident_byte(ptr[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= OUT_NONE;
      ptr  <= '0;
      left <= '0;
      wptr <= '0;
    end else begin
      if (ev_cmd) begin
        mode <= ev_status ? OUT_STAT : OUT_NONE;
        left <= '0;
      end else if (ev_load) begin
        mode <= OUT_PAGE;
        ptr  <= start_w;
        left <= len_w;
      end else if (ev_ident) begin
        mode <= OUT_IDENT;
        ptr  <= '0;
        left <= COLW'(4);
      end else if (take) begin
        ptr  <= ptr + 1'b1;
        left <= left - 1'b1;
      end
      if (ev_wstart)   wptr <= start_w;
      else if (buf_we) wptr <= wptr + 1'b1;
    end
  end

endmodule

// File: rtl/nand_status_reg.sv
module nand_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       arr_busy,
  input  logic       arr_done,
  input  logic       arr_fail,
  input  logic       ev_reset,
  output logic [7:0] status_byte,
  output logic       ready
);

  logic err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err <= 1'b0;
    else if (arr_done) err <= arr_fail;
    else if (ev_reset) err <= 1'b0;
  end

  assign ready       = ~arr_busy;
  assign status_byte = {wp_n, ready, 5'b00000, err};

endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
  import nand_if_pkg::*;
#(
  parameter int         PAGE_BYTES = 512,
  parameter logic [7:0] MANUF_ID   = 8'hEC,
  parameter logic [7:0] DEVICE_ID  = 8'h75,
  parameter logic [7:0] FILLER     = 8'h51,
  localparam int        TOTAL      = PAGE_BYTES + PAGE_BYTES / 32,
  localparam int        COLW       = $clog2(PAGE_BYTES + 256)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            cle,
  input  logic            ale,
  input  logic            wp_n,
  input  logic            spare_off,
  input  logic            wr_stb,
  input  logic [7:0]      din,
  input  logic            rd_stb,
  output logic [7:0]      dout,
  output logic            ready,
  output logic            load_req,
  output logic            prog_req,
  output logic            erase_req,
  output logic [15:0]     req_row,
  input  logic            arr_busy,
  input  logic            arr_done,
  input  logic            arr_fail,
  input  logic            fill_we,
  input  logic [COLW-1:0] fill_col,
  input  logic [7:0]      fill_data,
  input  logic [COLW-1:0] drain_col,
  output logic [7:0]      drain_data
);

  logic            ev_cmd, ev_status, ev_reset, ev_load, ev_wstart, ev_data, ev_ident;
  logic [7:0]      cur_col, rd_data, status_byte, buf_data;
  offs_t           cur_sel;
  logic [COLW-1:0] rd_col, buf_col;
  logic            buf_we, in_status;

  nand_cmd_decode u_dec (
    .clk, .rst_n, .ce_n, .cle, .ale, .wp_n, .wr_stb, .din,
    .ev_cmd, .ev_status, .ev_reset, .ev_load, .ev_wstart, .ev_data, .ev_ident,
    .cur_col, .cur_sel, .load_req, .prog_req, .erase_req, .req_row
  );

  nand_read_seq #(
    .PAGE_BYTES(PAGE_BYTES), .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID),
    .FILLER(FILLER), .COLW(COLW)
  ) u_seq (
    .clk, .rst_n, .ce_n, .rd_stb, .spare_off, .din,
    .ev_cmd, .ev_status, .ev_load, .ev_wstart, .ev_data, .ev_ident,
    .cur_col, .cur_sel, .rd_data, .status_byte,
    .dout, .rd_col, .buf_we, .buf_col, .buf_data, .in_status
  );

  nand_page_buf #(.TOTAL(TOTAL), .COLW(COLW)) u_buf (
    .clk, .fill_we, .fill_col, .fill_data,
    .host_we(buf_we), .host_col(buf_col), .host_data(buf_data),
    .rd_col, .rd_data, .drain_col, .drain_data
  );

  nand_status_reg u_stat (
    .clk, .rst_n, .wp_n, .arr_busy, .arr_done, .arr_fail, .ev_reset,
    .status_byte, .ready
  );

endmodule

// File: rtl/nand_cmd_if_chk.sv
module nand_cmd_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       wp_n,
  input logic [7:0] dout,
  input logic       load_req,
  input logic       prog_req,
  input logic       erase_req,
  input logic       arr_done,
  input logic       arr_fail,
  input logic       ev_reset,
  input logic       in_status,
  input logic [7:0] status_byte
);

  a_r11_ce_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> dout == 8'h00);

  a_r7_status_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (in_status && !ce_n) |-> dout == status_byte);

  a_r9_prog_guard: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(wp_n));

  a_r10_erase_guard: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wp_n));

  a_r14_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_req, prog_req, erase_req}));

  a_r14_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  a_r13_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> dout == 8'h00);

  a_r8_error_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_byte[0]) |-> $past(arr_done && arr_fail));

endmodule

bind nand_cmd_if nand_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wp_n(wp_n), .dout(dout),
  .load_req(load_req), .prog_req(prog_req), .erase_req(erase_req),
  .arr_done(arr_done), .arr_fail(arr_fail), .ev_reset(ev_reset),
  .in_status(in_status), .status_byte(status_byte)
);

// File: tb/nand_cmd_if_test.sv
module nand_cmd_if_test;

  localparam int PAGE  = 512;
  localparam int TOTAL = PAGE + PAGE / 32;
  localparam int COLW  = $clog2(PAGE + 256);

  logic clk = 0, rst_n = 0;
  logic ce_n = 0, cle = 0, ale = 0, wp_n = 1, spare_off = 0;
  logic wr_stb = 0, rd_stb = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic ready, load_req, prog_req, erase_req;
  logic [15:0] req_row;
  logic arr_busy = 0, arr_done = 0, arr_fail = 0, fill_we = 0;
  logic [COLW-1:0] fill_col = 0, drain_col = 0;
  logic [7:0] fill_data = 0;
  logic [7:0] drain_data;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nand_cmd_if uut (
    .clk, .rst_n, .ce_n, .cle, .ale, .wp_n, .spare_off, .wr_stb, .din, .rd_stb,
    .dout, .ready, .load_req, .prog_req, .erase_req, .req_row,
    .arr_busy, .arr_done, .arr_fail, .fill_we, .fill_col, .fill_data,
    .drain_col, .drain_data
  );

  function automatic logic [7:0] pat(input logic [15:0] row, input int col);
    return 8'(col * 7 + int'(row[7:0]) + 3);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; din = b; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; cle = 0; ale = 0;
  endtask

  task automatic cmd(input logic [7:0] b);  wr(1, 0, b); endtask
  task automatic adr(input logic [7:0] b);  wr(0, 1, b); endtask
  task automatic dat(input logic [7:0] b);  wr(0, 0, b); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    v = dout;
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic fill(input logic [15:0] row, input logic fail);
    @(negedge clk);
    arr_busy = 1;
    for (int c = 0; c < TOTAL; c++) begin
      fill_we = 1; fill_col = COLW'(c); fill_data = pat(row, c);
      @(negedge clk);
    end
    fill_we = 0; arr_busy = 0; arr_done = 1; arr_fail = fail;
    @(negedge clk);
    arr_done = 0; arr_fail = 0;
  endtask

  task automatic open_page(input logic [7:0] op, input logic [7:0] col, input logic [15:0] row);
    cmd(op); adr(col); adr(row[7:0]); adr(row[15:8]);
    check("R14 load_req", load_req, 1);
    check("R14 req_row", req_row, row);
    fill(row, 0);
  endtask

  task automatic drain(input int c, output logic [7:0] v);
    @(negedge clk);
    drain_col = COLW'(c);
    #1 v = drain_data;
  endtask

  task automatic t_reset();
    check("R1 dout", dout, 8'h00);
    check("R1 ready", ready, 1);
    check("R1 no request", {load_req, prog_req, erase_req}, 3'b000);
  endtask

  task automatic t_read_col();
    logic [7:0] v;
    int bad;
    cmd(8'h00); adr(8'h11); adr(8'h22);
    cmd(8'h00); adr(8'd250);
    check("R2 count restarts on command", load_req, 0);
    adr(8'h34); adr(8'h12);
    check("R2 load after third byte", load_req, 1);
    check("R14 row", req_row, 16'h1234);
    @(negedge clk);
    check("R14 single pulse", load_req, 0);
    fill(16'h1234, 0);
    bad = 0;
    for (int c = 250; c < TOTAL; c++) begin
      rd(v);
      if (v !== pat(16'h1234, c)) bad++;
    end
    check("R3 full page plus spare from column", bad, 0);
    rd(v);
    check("R3 exhausted returns 0", v, 8'h00);
    spare_off = 1;
    open_page(8'h00, 8'd250, 16'h1234);
    bad = 0;
    for (int c = 250; c < PAGE; c++) begin
      rd(v);
      if (v !== pat(16'h1234, c)) bad++;
    end
    check("R3 main area only", bad, 0);
    rd(v);
    check("R3 spare suppressed end", v, 8'h00);
    spare_off = 0;
  endtask

  task automatic t_read_half();
    logic [7:0] v;
    open_page(8'h01, 8'd5, 16'h0002);
    for (int c = 261; c < 264; c++) begin
      rd(v);
      check("R4 half offset data", v, pat(16'h0002, c));
    end
  endtask

  task automatic t_read_spare();
    logic [7:0] v;
    int bad;
    open_page(8'h50, 8'd3, 16'h0007);
    bad = 0;
    for (int c = PAGE + 3; c < TOTAL; c++) begin
      rd(v);
      if (v !== pat(16'h0007, c)) bad++;
    end
    check("R5 spare data", bad, 0);
    rd(v);
    check("R5 spare end", v, 8'h00);
    spare_off = 1;
    open_page(8'h50, 8'd3, 16'h0007);
    rd(v);
    check("R5 spare with suppress gives 0", v, 8'h00);
    spare_off = 0;
  endtask

  task automatic t_ident();
    logic [7:0] v;
    cmd(8'h90); adr(8'h00);
    rd(v); check("R6 manufacturer", v, 8'hEC);
    rd(v); check("R6 device", v, 8'h75);
    rd(v); check("R6 filler", v, 8'h51);
    rd(v); check("R6 last", v, 8'hC0);
    rd(v); check("R6 end", v, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    cmd(8'h70);
    rd(v); check("R7 status", v, 8'hC0);
    rd(v); check("R7 status repeats", v, 8'hC0);
    cmd(8'h42);
    rd(v); check("R12 unknown byte keeps echo", v, 8'hC0);
    @(negedge clk); wp_n = 0;
    rd(v); check("R7 protect bit follows wp_n", v, 8'h40);
    @(negedge clk); wp_n = 1; arr_busy = 1;
    rd(v); check("R7 ready bit", v, 8'h80);
    @(negedge clk); arr_busy = 0;
    cmd(8'h00);
    rd(v); check("R7 new command ends echo", v, 8'h00);
  endtask

  task automatic t_error();
    logic [7:0] v;
    fill(16'h0001, 1);
    cmd(8'h70);
    rd(v); check("R8 error set", v, 8'hC1);
    cmd(8'hFF); cmd(8'h70);
    rd(v); check("R8 reset clears error", v, 8'hC0);
  endtask

  task automatic t_reset_cmd();
    logic [7:0] v;
    cmd(8'h01); cmd(8'hFF);
    check("R13 output idle", dout, 8'h00);
    adr(8'd9); adr(8'h03); adr(8'h00);
    check("R13 read mode after reset", load_req, 1);
    fill(16'h0003, 0);
    rd(v); check("R13 offset cleared", v, pat(16'h0003, 9));
  endtask

  task automatic t_prog();
    logic [7:0] v, keep0, keep1;
    cmd(8'h80); adr(8'd10); adr(8'h05);
    adr(8'h00);
    check("R9 setup raises no load", load_req, 0);
    dat(8'hAA); dat(8'hBB); dat(8'hCC);
    cmd(8'h10);
    check("R9 prog_req", prog_req, 1);
    check("R9 prog row", req_row, 16'h0005);
    drain(10, v); check("R9 byte 0", v, 8'hAA);
    drain(11, v); check("R9 byte 1", v, 8'hBB);
    drain(12, v); check("R9 byte 2", v, 8'hCC);
    drain(0, keep0); drain(1, keep1);
    cmd(8'h50); cmd(8'h80); adr(8'd14); adr(8'h05); adr(8'h00);
    dat(8'h11); dat(8'h22); dat(8'h33); dat(8'h44);
    drain(PAGE + 14, v); check("R9 spare write", v, 8'h11);
    drain(PAGE + 15, v); check("R9 last byte", v, 8'h22);
    drain(0, v); check("R9 no wrap 0", v, keep0);
    drain(1, v); check("R9 no wrap 1", v, keep1);
    @(negedge clk); wp_n = 0;
    cmd(8'h10);
    check("R9 protected no prog", prog_req, 0);
    @(negedge clk); wp_n = 1;
  endtask

  task automatic t_erase();
    cmd(8'h60); adr(8'h34); adr(8'h12); cmd(8'hD0);
    check("R10 erase_req", erase_req, 1);
    check("R10 erase row", req_row, 16'h1234);
    @(negedge clk); wp_n = 0;
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
    check("R10 protected no erase", erase_req, 0);
    @(negedge clk); wp_n = 1;
  endtask

  task automatic t_ce();
    logic [7:0] v;
    open_page(8'h00, 8'd20, 16'h0009);
    @(negedge clk); ce_n = 1;
    rd(v); check("R11 deselected output 0", v, 8'h00);
    rd(v);
    cmd(8'h70);
    @(negedge clk); ce_n = 0;
    rd(v); check("R11 strobes ignored", v, pat(16'h0009, 20));
    rd(v); check("R11 continues", v, pat(16'h0009, 21));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_col();
    t_read_half();
    t_read_spare();
    t_ident();
    t_status();
    t_error();
    t_reset_cmd();
    t_prog();
    t_erase();
    t_ce();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule